// File: doc/BRIEF.md
# Flash command sequence controller

This block is the command front end of a byte-wide flash array. It watches the write cycles on a simple synchronous bus and decodes multi-write unlock sequences. A sequence can start a byte program, start a sector erase, or switch the read path into identification mode. A started operation runs for a fixed number of clocks, counted by a timer that stands in for the real cell timing. During that time `ready` is low and every read returns a status byte in place of array data. When the count expires, the controller commits the result through a plain array port: one merged write for a program, or one erase pulse naming the sector.

The array is outside the block, so in simulation it is a behavioural model in the bench. The controller reads the old byte through the same array port and writes back the old byte ANDed with the new one. Programming can therefore only clear bits, and only an erase brings them back to 1.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The writes AAh to 5555h, 55h to 2AAAh and A0h to 5555h, followed by a fourth write of the data byte to the target, start a program. Unlock addresses are compared on address bits [14:0] only. `ready` is low for exactly PROG_CYC clocks, starting on the clock after the fourth write.
- R2: A completed program stores the old byte ANDed with the written byte at the target, so bits can only go from 1 to 0.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 30h to any address start a sector erase. The sector is addr[ADDR_W-1 -: log2(SECTORS)]. Afterwards every byte of that sector reads FFh, and other sectors are untouched. `ready` is low for exactly ERASE_CYC clocks.
- R4: A write whose address or data does not continue the sequence in progress returns the decoder to idle. No operation starts and no byte changes.
- R5: Every write while `ready` is low is ignored, including the write in the final busy clock, F0h, and complete command sequences.
- R6: A read while busy returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, and 0 during an erase. Bit 5, the timeout flag, reads 0, and bits 4:0 read 0.
- R7: Bit 6 of the status byte is 0 on the first read after a start and inverts on every further busy read. The first read after completion returns array data.
- R8: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. Full address 0 then reads MFR_ID, address 1 reads DEV_ID and any other address reads 00h. In this mode every write other than F0h is ignored.
- R9: F0h written to any address leaves identification mode. In the middle of a sequence, F0h breaks it (R4). As the fourth write of a program it is ordinary data.
- R10: After reset `ready` is high, `rdata` is 00h, no array write or erase is requested, and the block is in array read mode.
- R11: `rdata` is registered. It takes its new value on the clock edge that samples `rd_en` high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 8 | Bus write data |
| wr_en | input | 1 | Write strobe, one per clock |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| ready | output | 1 | High when no operation runs |
| mem_addr | output | ADDR_W | Array address: bus address when idle, operation target when busy |
| mem_wdata | output | 8 | Merged byte for the array write |
| mem_we | output | 1 | Array byte write, one clock at program completion |
| mem_erase | output | 1 | Sector erase pulse, one clock at erase completion |
| mem_sector | output | log2(SECTORS) | Sector to erase |
| mem_rdata | input | 8 | Array byte at mem_addr |

## Verification
The last busy clock is where two functions meet. In that clock the timer commits the byte to the array, while a read strobe or a command write can arrive on the bus in the same clock. The bench places its reads so that the final status read lands exactly in the completion clock: it must still get a status byte, and the next read must get the merged data. A separate case sends an unlock write in that clock: it must be ignored, so the rest of the sequence that follows must start nothing and leave the target byte unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERS1, SQ_ERS2, SQ_ERS3
  } seq_t;

  typedef enum logic [1:0] {OP_NONE, OP_PGM, OP_ERS} op_t;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PGM   = 8'hA0;
  localparam logic [7:0] CMD_ERS   = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;

  // program can only clear bits
  function automatic logic [7:0] merge_program(input logic [7:0] old_b,
                                               input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // busy status: inverted data bit 7, toggle, timeout flag, zeros
  function automatic logic [7:0] status_byte(input logic d7, input logic tog);
    return {~d7, tog, 1'b0, 5'b00000};
  endfunction

  function automatic logic [7:0] id_byte(input logic sel_mfr, input logic sel_dev,
                                         input logic [7:0] mfr, input logic [7:0] dev);
    if (sel_mfr) return mfr;
    if (sel_dev) return dev;
    return 8'h00;
  endfunction

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int UNLOCK_W = 15,
  parameter logic [UNLOCK_W-1:0] UNL_ADDR_A = 15'h5555,
  parameter logic [UNLOCK_W-1:0] UNL_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              busy,
  output logic              start_prog,
  output logic              start_erase,
  output logic              id_mode
);

  seq_t seq_q, seq_d;
  logic id_q, id_d;
  logic hit_a, hit_b, accept;

  assign hit_a  = (addr[UNLOCK_W-1:0] == UNL_ADDR_A);
  assign hit_b  = (addr[UNLOCK_W-1:0] == UNL_ADDR_B);
  assign accept = wr_en && !busy;

  always_comb begin
    seq_d       = seq_q;
    id_d        = id_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    if (accept) begin
      seq_d = SQ_IDLE;
      if (id_q) begin
        if (wdata == CMD_EXIT) id_d = 1'b0;
      end else begin
        case (seq_q)
          SQ_IDLE: if (hit_a && wdata == CMD_UNL1) seq_d = SQ_UNL1;
          SQ_UNL1: if (hit_b && wdata == CMD_UNL2) seq_d = SQ_UNL2;
          SQ_UNL2: begin
            if (hit_a && wdata == CMD_PGM)        seq_d = SQ_PGM;
            else if (hit_a && wdata == CMD_ERS)   seq_d = SQ_ERS1;
            else if (hit_a && wdata == CMD_IDENT) id_d  = 1'b1;
          end
          SQ_PGM:  start_prog = 1'b1;
          SQ_ERS1: if (hit_a && wdata == CMD_UNL1) seq_d = SQ_ERS2;
          SQ_ERS2: if (hit_b && wdata == CMD_UNL2) seq_d = SQ_ERS3;
          SQ_ERS3: if (wdata == CMD_SECT) start_erase = 1'b1;
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      id_q  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      id_q  <= id_d;
    end
  end

  assign id_mode = id_q;

  // R9: exit command leaves identification mode
  a_r9_exit_ident: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode && wr_en && !busy && wdata == CMD_EXIT |=> !id_mode);

  // R8: identification mode only entered by a written 90h
  a_r8_ident_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en && wdata == CMD_IDENT));

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              busy,
  output logic              done,
  output op_t               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      op_kind <= OP_NONE;
      op_addr <= '0;
      op_data <= 8'h00;
    end else if (start_prog) begin
      busy    <= 1'b1;
      cnt_q   <= PROG_LOAD;
      op_kind <= OP_PGM;
      op_addr <= addr;
      op_data <= wdata;
    end else if (start_erase) begin
      busy    <= 1'b1;
      cnt_q   <= ERASE_LOAD;
      op_kind <= OP_ERS;
      op_addr <= addr;
      op_data <= 8'hFF;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1: busy only begins after a decoded start
  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_prog || start_erase));

  // R3: completion ends the busy period on the next clock
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R5: a running operation keeps its target and kind
  a_r5_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(op_addr) && $stable(op_kind) && $stable(op_data));

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter logic [7:0] MFR_ID = 8'hC5,
  parameter logic [7:0] DEV_ID = 8'h3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              op_start,
  input  logic              op_d7,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        rdata
);

  logic tog_q;
  logic [7:0] rd_sel;

  always_comb begin
    if (busy)         rd_sel = status_byte(op_d7, tog_q);
    else if (id_mode) rd_sel = id_byte(addr == '0, addr == ADDR_W'(1), MFR_ID, DEV_ID);
    else              rd_sel = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      rdata <= 8'h00;
    end else begin
      if (op_start)            tog_q <= 1'b0;
      else if (rd_en && busy)  tog_q <= ~tog_q;
      if (rd_en) rdata <= rd_sel;
    end
  end

  // R7: each busy read flips the toggle bit
  a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_en |=> tog_q != $past(tog_q));

  // R6: timeout flag and low status bits read zero while busy
  a_r6_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_en |=> rdata[5:0] == 6'd0);

  // R11: read data holds without a strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 19,
  parameter int         SECTORS   = 8,
  parameter int         UNLOCK_W  = 15,
  parameter int         PROG_CYC  = 40,
  parameter int         ERASE_CYC = 2000,
  parameter logic [7:0] MFR_ID    = 8'hC5,
  parameter logic [7:0] DEV_ID    = 8'h3B,
  localparam int        SECT_W    = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_erase,
  output logic [SECT_W-1:0] mem_sector,
  input  logic [7:0]        mem_rdata
);

  logic              start_prog, start_erase, id_mode;
  logic              busy, done;
  op_t               op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;

  flash_seq_decoder #(
    .ADDR_W(ADDR_W), .UNLOCK_W(UNLOCK_W),
    .UNL_ADDR_A(UNLOCK_W'(16'h5555)), .UNL_ADDR_B(UNLOCK_W'(16'h2AAA))
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .busy(busy), .start_prog(start_prog), .start_erase(start_erase),
    .id_mode(id_mode)
  );

  flash_op_timer #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  flash_read_path #(
    .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
    .op_start(start_prog || start_erase), .op_d7(op_data[7]),
    .id_mode(id_mode), .addr(addr), .mem_rdata(mem_rdata), .rdata(rdata)
  );

  assign ready      = !busy;
  assign mem_addr   = busy ? op_addr : addr;
  assign mem_wdata  = merge_program(mem_rdata, op_data);
  assign mem_we     = done && (op_kind == OP_PGM);
  assign mem_erase  = done && (op_kind == OP_ERS);
  assign mem_sector = op_addr[ADDR_W-1 -: SECT_W];

  // R2: an array write never sets a bit that was clear
  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata & ~mem_rdata) == 8'h00);

  // R5: writes while busy never start a new operation
  a_r5_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_prog && !start_erase);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int ADDR_W = 19;
  localparam int PCYC   = 4;
  localparam int ECYC   = 10;
  localparam logic [7:0] MFR = 8'hC5;
  localparam logic [7:0] DEV = 8'h3B;
  localparam logic [ADDR_W-1:0] UA = 19'h05555;
  localparam logic [ADDR_W-1:0] UB = 19'h02AAA;

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata, mem_wdata, mem_rdata;
  logic wr_en, rd_en, ready, mem_we, mem_erase;
  logic [ADDR_W-1:0] mem_addr;
  logic [2:0] mem_sector;

  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .SECTORS(8), .UNLOCK_W(15),
                   .PROG_CYC(PCYC), .ERASE_CYC(ECYC), .MFR_ID(MFR), .DEV_ID(DEV))
  i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .ready(ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_erase(mem_erase),
    .mem_sector(mem_sector), .mem_rdata(mem_rdata)
  );

  // behavioural array driven by the block's array port
  logic [7:0] arr [int unsigned];
  int unsigned kill_q[$];

  always @(negedge clk)
    mem_rdata <= arr.exists(32'(mem_addr)) ? arr[32'(mem_addr)] : 8'hFF;

  always @(posedge clk) begin
    if (mem_we) arr[32'(mem_addr)] = mem_wdata;
    if (mem_erase) begin
      kill_q.delete();
      foreach (arr[k]) if ((k >> 16) == 32'(mem_sector)) kill_q.push_back(k);
      foreach (kill_q[i]) arr.delete(kill_q[i]);
    end
  end

  // expected contents, kept by the bench alone
  logic [7:0] ref_mem [int unsigned];

  function automatic logic [7:0] ref_rd(input logic [ADDR_W-1:0] a);
    return ref_mem.exists(32'(a)) ? ref_mem[32'(a)] : 8'hFF;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_quiet(input logic [ADDR_W-1:0] tgt, input string tag);
    logic [7:0] v;
    wr(tgt, 8'h00);
    chk(ready == 1'b1, tag, ready, 1);
    idle(1);
    chk(ready == 1'b1, tag, ready, 1);
    rd(tgt, v);
    chk(v == ref_rd(tgt), tag, v, ref_rd(tgt));
  endtask

  task automatic do_program(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic [7:0] v;
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, d);
    chk(ready == 1'b0, "R1 ready low after start", ready, 0);
    for (int j = 0; j < PCYC; j++) begin
      rd(a, v);
      chk(v == {~d[7], j[0], 6'b0}, "R6 R7 program status", v, {~d[7], j[0], 6'b0});
      if (j < PCYC - 1) chk(ready == 1'b0, "R1 busy length", ready, 0);
      else              chk(ready == 1'b1, "R1 busy length", ready, 1);
    end
    ref_mem[32'(a)] = ref_rd(a) & d;
    rd(a, v);
    chk(v == ref_rd(a), "R2 R7 merged data", v, ref_rd(a));
  endtask

  task automatic erase_seq(input logic [ADDR_W-1:0] a);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h80);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(a, 8'h30);
  endtask

  task automatic ref_erase(input logic [ADDR_W-1:0] a);
    kill_q.delete();
    foreach (ref_mem[k]) if ((k >> 16) == 32'(a >> 16)) kill_q.push_back(k);
    foreach (kill_q[i]) ref_mem.delete(kill_q[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [ADDR_W-1:0] a;
    rst_n = 1'b0; addr = '0; wdata = 8'h00; wr_en = 1'b0; rd_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    chk(ready == 1'b1, "R10 ready", ready, 1);
    chk(rdata == 8'h00, "R10 rdata", rdata, 0);
    chk(!mem_we && !mem_erase, "R10 no array op", {mem_we, mem_erase}, 0);
    rd(19'h00123, v);
    chk(v == 8'hFF, "R10 array read mode", v, 8'hFF);
    idle(2);
    chk(rdata == 8'hFF, "R11 rdata holds", rdata, 8'hFF);

    // program sweep, one byte per sector
    for (int i = 0; i < 8; i++) begin
      a = ADDR_W'((i << 16) | (i * 32'h111 + 3));
      do_program(a, 8'h5A ^ 8'(i * 37));
    end
    do_program(19'h00003, 8'h0F);        // R2 re-program clears more bits
    do_program(19'h00003, 8'hFF);        // R2 ones do not come back
    do_program(19'h1E000, 8'hF0);        // R9 F0 as program data

    // erase sector 2 with status reads (R3 R6 R7)
    a = 19'h2ABCD;
    do_program(19'h20040, 8'h12);
    erase_seq(a);
    chk(ready == 1'b0, "R3 ready low after start", ready, 0);
    for (int j = 0; j < ECYC; j++) begin
      rd(a, v);
      chk(v == {1'b0, j[0], 6'b0}, "R6 R7 erase status", v, {1'b0, j[0], 6'b0});
      if (j < ECYC - 1) chk(ready == 1'b0, "R3 busy length", ready, 0);
      else              chk(ready == 1'b1, "R3 busy length", ready, 1);
    end
    ref_erase(a);
    for (int i = 0; i < 8; i++) begin
      a = ADDR_W'((i << 16) | (i * 32'h111 + 3));
      rd(a, v);
      chk(v == ref_rd(a), "R3 sector contents", v, ref_rd(a));
    end
    rd(19'h20040, v);
    chk(v == 8'hFF, "R3 erased byte", v, 8'hFF);

    // R5 writes during an erase are ignored
    erase_seq(19'h50000);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(19'h66669, 8'h00);
    wr(19'h00000, 8'hF0);
    idle(ECYC);
    ref_erase(19'h50000);
    chk(ready == 1'b1, "R5 no op started", ready, 1);
    rd(19'h66669, v);
    chk(v == ref_rd(19'h66669), "R5 target untouched", v, ref_rd(19'h66669));
    check_quiet(19'h66669, "R5 decoder idle after busy");

    // R4 broken sequences at each stage
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 2; m++) begin
        if (s > 0) wr(UA, 8'hAA);
        if (s > 1) wr(UB, 8'h55);
        if (m == 0) wr(s == 1 ? UB : UA, 8'h11);           // wrong data
        else        wr(19'h01234, s == 0 ? 8'hAA : s == 1 ? 8'h55 : 8'hA0); // wrong address
        check_quiet(19'h00003, "R4 broken program sequence");
      end
    end
    for (int s = 3; s < 6; s++) begin
      wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h80);
      if (s > 3) wr(UA, 8'hAA);
      if (s > 4) wr(UB, 8'h55);
      wr(s == 4 ? UB : UA, 8'h31);
      check_quiet(19'h00003, "R4 broken erase sequence");
    end
    // R9 F0 inside a sequence breaks it
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hF0);
    check_quiet(19'h10114, "R9 F0 breaks sequence");

    // R8 identification mode
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h90);
    rd(19'h00000, v); chk(v == MFR, "R8 manufacturer", v, MFR);
    rd(19'h00001, v); chk(v == DEV, "R8 device", v, DEV);
    rd(19'h00002, v); chk(v == 8'h00, "R8 other address", v, 0);
    rd(19'h10000, v); chk(v == 8'h00, "R8 high address", v, 0);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(19'h00003, 8'h00);
    chk(ready == 1'b1, "R8 writes ignored", ready, 1);
    rd(19'h00001, v); chk(v == DEV, "R8 still in id mode", v, DEV);
    wr(19'h4321F, 8'hF0);
    rd(19'h00003, v);
    chk(v == ref_rd(19'h00003), "R9 back to array read", v, ref_rd(19'h00003));

    // completion clock: a write there is ignored
    a = 19'h70707;
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, 8'h3C);
    for (int j = 0; j < PCYC - 1; j++) rd(a, v);
    wr(UA, 8'hAA);                         // lands in the final busy clock
    ref_mem[32'(a)] = ref_rd(a) & 8'h3C;
    chk(ready == 1'b1, "R5 completion reached", ready, 1);
    wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, 8'h00);
    chk(ready == 1'b1, "R5 completion-clock write ignored", ready, 1);
    rd(a, v);
    chk(v == ref_rd(a), "R5 target after completion", v, ref_rd(a));

    finish_run();
  end

endmodule